// File: doc/BRIEF.md
# Coprocessor Integer ALU with Register File

This block runs the arithmetic and logic instructions of a small low-power coprocessor. It holds four 16-bit general registers. Each cycle it can accept one 32-bit instruction word, qualified by a valid strobe. If the word belongs to the ALU class, the block reads the source registers and forms the result. It then writes the result back and updates the zero and overflow conditions that later conditional jumps test. There are two operand forms. One takes both operands from registers. The other takes the second operand from a 16-bit immediate carried in the instruction.

Instructions of other classes are left to other units and pass through with no effect. This includes the stage-counter operations that share the ALU major code. A malformed ALU word writes nothing, leaves the flags untouched and raises a one-cycle illegal-instruction pulse. A combinational debug port shows the contents of any register.

A small state machine records the outcome of the last accepted edge. It has three states: `ST_IDLE` (nothing executed), `ST_WROTE` (a legal ALU instruction committed) and `ST_TRAP` (a malformed ALU instruction was rejected). On every clock edge it moves to `ST_WROTE` on a legal ALU word, to `ST_TRAP` on a malformed one, and to `ST_IDLE` on anything else. Reset forces `ST_IDLE`.

Top module: `cpalu_unit`

## Requirements
- R1: A synchronous, active-high reset clears all four registers and both flags, and drives `illegal_o` low.
- R2: An ALU word has bits [31:28] = 7, and bits [27:25] select the form: 0 means register-register and 1 means register-immediate. In the register-register form the destination is bits [1:0], source 1 is bits [3:2] and source 2 is bits [5:4]. In the register-immediate form the destination is bits [1:0], source 1 is bits [3:2] and the 16-bit immediate is bits [19:4]. The operation code is bits [24:21].
- R3: Operation 0 adds and operation 1 subtracts (source 1 minus the second operand), both modulo 2^16. Overflow is set by the carry out of the add or by the borrow of the subtract (source 1 below the second operand).
- R4: Operation 2 is bitwise AND and operation 3 is bitwise OR.
- R5: Operation 4 (move) writes source 1 in the register form or the immediate in the immediate form. The source 2 field does not affect the result.
- R6: Operation 5 shifts left and operation 6 shifts right, with zeros filling in. The shift amount is the whole 16-bit second operand, and an amount of 16 or more gives 0.
- R7: Each executed operation sets the zero flag exactly when its result is 0. Operations other than add and subtract clear the overflow flag.
- R8: The register write and the flag update appear after the rising edge on which the valid strobe is high. With valid low, nothing changes.
- R9: A malformed ALU word writes no register and leaves both flags unchanged. A word is malformed if it has form 0 or 1 with operation 7 to 15, or form 3 to 7. It also raises `illegal_o` for exactly the cycle after that edge.
- R10: A word whose bits [31:28] are not 7, or an ALU word with form 2, changes no register and no flag, and leaves `illegal_o` low.
- R11: `dbg_data_o` shows, without delay, the register selected by `dbg_sel_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr_i | input | 32 | Instruction word |
| instr_valid_i | input | 1 | Instruction qualifier |
| dbg_sel_i | input | 2 | Register index for the debug read |
| dbg_data_o | output | 16 | Contents of the selected register |
| zero_flag_o | output | 1 | Result of the last executed operation was zero |
| ovf_flag_o | output | 1 | Last add carried or last subtract borrowed |
| illegal_o | output | 1 | One-cycle pulse after a malformed ALU word |

## Verification
The assertions check, on every cycle, the following properties:
- a register write lands at the addressed register with the written value;
- the flags hold through idle and trap cycles;
- overflow is clear after any logical, move or shift operation;
- an illegal pulse only ever follows an ALU-class word;
- an add without carry never produces a result below source 1.

Only the bench's scenarios can show certain other behaviour:
- the arithmetic values themselves;
- shift saturation at 16 and above;
- that the source 2 field is ignored by move;
- the exact field positions;
- that foreign classes and form 2 pass without effect.

The bench checks these behaviours against a model of the register file, across directed corner cases and a long random stream.

// File: rtl/cpalu_pkg.sv
package cpalu_pkg;

    localparam int DATA_W   = 16;
    localparam int NUM_REGS = 4;
    localparam int REG_AW   = $clog2(NUM_REGS);
    localparam int SH_W     = $clog2(DATA_W);

    localparam logic [3:0] MAJOR_ALU  = 4'd7;
    localparam logic [2:0] FORM_RR    = 3'd0;
    localparam logic [2:0] FORM_RI    = 3'd1;
    localparam logic [2:0] FORM_STAGE = 3'd2;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_MOVE = 4'd4,
        OP_LSH  = 4'd5,
        OP_RSH  = 4'd6
    } alu_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WROTE = 2'd1,
        ST_TRAP  = 2'd2
    } exec_state_e;

    typedef struct packed {
        logic              commit;
        logic              trap;
        logic              use_imm;
        alu_op_e           op;
        logic [REG_AW-1:0] dst;
        logic [REG_AW-1:0] src1;
        logic [REG_AW-1:0] src2;
        logic [DATA_W-1:0] imm;
    } decoded_t;

endpackage

// File: rtl/cpalu_decode.sv
module cpalu_decode
    import cpalu_pkg::*;
(
    input  logic [31:0] instr_i,
    input  logic        valid_i,
    output decoded_t    dec_o
);

    logic [3:0] major;
    logic [2:0] form;
    logic [3:0] subop;

    assign major = instr_i[31:28];
    assign form  = instr_i[27:25];
    assign subop = instr_i[24:21];

    always_comb begin
        dec_o         = '0;
        dec_o.dst     = instr_i[1:0];
        dec_o.src1    = instr_i[3:2];
        dec_o.src2    = instr_i[5:4];
        dec_o.imm     = instr_i[19:4];
        dec_o.use_imm = (form == FORM_RI);
        dec_o.op      = OP_ADD;
        if (valid_i && major == MAJOR_ALU) begin
            if (form == FORM_RR || form == FORM_RI) begin
                if (subop <= 4'd6) begin
                    dec_o.commit = 1'b1;
                    dec_o.op     = alu_op_e'(subop);
                end else begin
                    dec_o.trap = 1'b1;
                end
            end else if (form != FORM_STAGE) begin
                dec_o.trap = 1'b1;
            end
        end
    end

endmodule

// File: rtl/cpalu_exec.sv
module cpalu_exec
    import cpalu_pkg::*;
(
    input  alu_op_e           op_i,
    input  logic              use_imm_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] res_o,
    output logic              carry_o
);

    logic [DATA_W:0] sum_ext;
    logic [DATA_W:0] diff_ext;
    logic            big_shift;

    assign sum_ext   = {1'b0, a_i} + {1'b0, b_i};
    assign diff_ext  = {1'b0, a_i} - {1'b0, b_i};
    assign big_shift = (b_i >= DATA_W[DATA_W-1:0]);

    always_comb begin
        res_o   = '0;
        carry_o = 1'b0;
        unique case (op_i)
            OP_ADD: begin
                res_o   = sum_ext[DATA_W-1:0];
                carry_o = sum_ext[DATA_W];
            end
            OP_SUB: begin
                res_o   = diff_ext[DATA_W-1:0];
                carry_o = diff_ext[DATA_W];
            end
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_MOVE: res_o = use_imm_i ? b_i : a_i;
            OP_LSH:  res_o = big_shift ? '0 : (a_i << b_i[SH_W-1:0]);
            OP_RSH:  res_o = big_shift ? '0 : (a_i >> b_i[SH_W-1:0]);
            default: res_o = '0;
        endcase
    end

    always_comb begin
        if (op_i == OP_ADD && !carry_o) begin
            AST_ADD_NO_WRAP: assert (res_o >= a_i); // R3
        end
    end

endmodule

// File: rtl/cpalu_regfile.sv
module cpalu_regfile #(
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 4,
    localparam int AW      = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [AW-1:0]     waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [AW-1:0]     ra1_i,
    input  logic [AW-1:0]     ra2_i,
    input  logic [AW-1:0]     rdbg_i,
    output logic [DATA_W-1:0] rd1_o,
    output logic [DATA_W-1:0] rd2_o,
    output logic [DATA_W-1:0] rdbg_o
);

    logic [DATA_W-1:0] regs_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[g] <= '0;
            end else if (we_i && waddr_i == AW'(g)) begin
                regs_q[g] <= wdata_i;
            end
        end
    end

    assign rd1_o  = regs_q[ra1_i];
    assign rd2_o  = regs_q[ra2_i];
    assign rdbg_o = regs_q[rdbg_i];

    logic armed_q;
    always_ff @(posedge clk) begin
        if (rst) armed_q <= 1'b0;
        else     armed_q <= 1'b1;
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst || !armed_q)
        $past(we_i) |-> regs_q[$past(waddr_i)] == $past(wdata_i)); // R8

endmodule

// File: rtl/cpalu_unit.sv
module cpalu_unit
    import cpalu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] instr_i,
    input  logic        instr_valid_i,
    input  logic [1:0]  dbg_sel_i,
    output logic [15:0] dbg_data_o,
    output logic        zero_flag_o,
    output logic        ovf_flag_o,
    output logic        illegal_o
);

    decoded_t          dec;
    logic [DATA_W-1:0] rd1, rd2, opnd_b, result;
    logic              carry;
    exec_state_e       state_q, state_d;
    logic              zero_q, ovf_q;

    cpalu_decode u_decode (
        .instr_i (instr_i),
        .valid_i (instr_valid_i),
        .dec_o   (dec)
    );

    cpalu_regfile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we_i    (dec.commit),
        .waddr_i (dec.dst),
        .wdata_i (result),
        .ra1_i   (dec.src1),
        .ra2_i   (dec.src2),
        .rdbg_i  (dbg_sel_i),
        .rd1_o   (rd1),
        .rd2_o   (rd2),
        .rdbg_o  (dbg_data_o)
    );

    assign opnd_b = dec.use_imm ? dec.imm : rd2;

    cpalu_exec u_exec (
        .op_i      (dec.op),
        .use_imm_i (dec.use_imm),
        .a_i       (rd1),
        .b_i       (opnd_b),
        .res_o     (result),
        .carry_o   (carry)
    );

    // Next-state selection
    always_comb begin
        if (dec.commit)    state_d = ST_WROTE;
        else if (dec.trap) state_d = ST_TRAP;
        else               state_d = ST_IDLE;
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Flag outputs, updated only on committed operations
    always_ff @(posedge clk) begin
        if (rst) begin
            zero_q <= 1'b0;
            ovf_q  <= 1'b0;
        end else if (dec.commit) begin
            zero_q <= (result == '0);
            ovf_q  <= carry;
        end
    end

    always_comb begin
        illegal_o = 1'b0;
        unique case (state_q)
            ST_IDLE:  illegal_o = 1'b0;
            ST_WROTE: illegal_o = 1'b0;
            ST_TRAP:  illegal_o = 1'b1;
            default:  illegal_o = 1'b0;
        endcase
    end

    assign zero_flag_o = zero_q;
    assign ovf_flag_o  = ovf_q;

    logic armed_q;
    always_ff @(posedge clk) begin
        if (rst) armed_q <= 1'b0;
        else     armed_q <= 1'b1;
    end

    AST_TRAP_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst || !armed_q)
        (state_q == ST_TRAP) |-> $stable({zero_q, ovf_q})); // R9
    AST_IDLE_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst || !armed_q)
        (state_q == ST_IDLE) |-> $stable({zero_q, ovf_q})); // R8
    AST_OVF_CLEAR_NONARITH: assert property (@(posedge clk) disable iff (rst || !armed_q)
        (state_q == ST_WROTE && $past(dec.op) != OP_ADD && $past(dec.op) != OP_SUB)
        |-> !ovf_q); // R7
    AST_TRAP_FROM_ALU: assert property (@(posedge clk) disable iff (rst || !armed_q)
        illegal_o |-> ($past(instr_i[31:28]) == MAJOR_ALU && $past(instr_valid_i))); // R9

endmodule

// File: tb/cpalu_unit_tb.sv
module cpalu_unit_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] instr;
    logic        valid;
    logic [1:0]  dbg_sel;
    logic [15:0] dbg_data;
    logic        zf, of, ill;

    always #10 clk = ~clk;

    cpalu_unit u_dut (
        .clk           (clk),
        .rst           (rst),
        .instr_i       (instr),
        .instr_valid_i (valid),
        .dbg_sel_i     (dbg_sel),
        .dbg_data_o    (dbg_data),
        .zero_flag_o   (zf),
        .ovf_flag_o    (of),
        .illegal_o     (ill)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    logic [15:0] m_regs [4];
    logic        m_z, m_o, m_ill;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rr(input logic [3:0] sub, input logic [1:0] d,
                                       input logic [1:0] s1, input logic [1:0] s2);
        return {4'd7, 3'd0, sub, 15'd0, s2, s1, d};
    endfunction

    function automatic logic [31:0] ri(input logic [3:0] sub, input logic [1:0] d,
                                       input logic [1:0] s1, input logic [15:0] imm);
        return {4'd7, 3'd1, sub, 1'b0, imm, s1, d};
    endfunction

    function automatic string tag_of(input logic [31:0] ins);
        if (ins[31:28] != 4'd7 || ins[27:25] == 3'd2) return "R10";
        if (ins[27:25] > 3'd2 || ins[24:21] > 4'd6)   return "R9";
        case (ins[24:21])
            4'd0, 4'd1: return "R3";
            4'd2, 4'd3: return "R4";
            4'd4:       return "R5";
            default:    return "R6";
        endcase
    endfunction

    task automatic model_step(input logic [31:0] ins, input logic vld);
        logic [15:0] a, b, r;
        logic        c;
        m_ill = 1'b0;
        if (!vld || ins[31:28] != 4'd7 || ins[27:25] == 3'd2) return;
        if (ins[27:25] > 3'd2 || ins[24:21] > 4'd6) begin
            m_ill = 1'b1;
            return;
        end
        a = m_regs[ins[3:2]];
        b = (ins[27:25] == 3'd1) ? ins[19:4] : m_regs[ins[5:4]];
        c = 1'b0;
        case (ins[24:21])
            4'd0: {c, r} = {1'b0, a} + {1'b0, b};
            4'd1: begin r = a - b; c = (a < b); end
            4'd2: r = a & b;
            4'd3: r = a | b;
            4'd4: r = (ins[27:25] == 3'd1) ? b : a;
            4'd5: r = (b >= 16) ? 16'd0 : a << b[3:0];
            default: r = (b >= 16) ? 16'd0 : a >> b[3:0];
        endcase
        m_regs[ins[1:0]] = r;
        m_z = (r == 16'd0);
        m_o = c;
    endtask

    task automatic compare_all(input string tag);
        for (int r = 0; r < 4; r++) begin
            dbg_sel = r[1:0];
            #1;
            chk({tag, " reg R11"}, {16'd0, dbg_data}, {16'd0, m_regs[r]});
        end
        chk("R7 zero", {31'd0, zf}, {31'd0, m_z});
        chk({tag, " R7 ovf"}, {31'd0, of}, {31'd0, m_o});
        chk("R9 illegal", {31'd0, ill}, {31'd0, m_ill});
    endtask

    task automatic issue(input logic [31:0] ins, input logic vld, input string tag);
        instr = ins;
        valid = vld;
        @(posedge clk);
        model_step(ins, vld);
        @(negedge clk);
        valid = 1'b0;
        compare_all(tag);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        valid = 1'b0;
        instr = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        for (int r = 0; r < 4; r++) m_regs[r] = '0;
        m_z = 1'b0; m_o = 1'b0; m_ill = 1'b0;
        compare_all("R1");
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<190000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad);
            $finish;
        end
    end

    initial begin
        dbg_sel = '0;
        void'($urandom(32'd2718));
        do_reset();

        // R3: add with carry out to zero, R7 zero flag
        issue(ri(4'd4, 2'd0, 2'd3, 16'hFFFF), 1'b1, "R5");
        issue(ri(4'd0, 2'd1, 2'd0, 16'd1), 1'b1, "R3");
        // R5: move immediate ignores the source 1 field; register move ignores the source 2 field
        issue(ri(4'd4, 2'd2, 2'd1, 16'd5), 1'b1, "R5");
        issue(rr(4'd4, 2'd3, 2'd2, 2'd0), 1'b1, "R5");
        // R3: subtract with borrow
        issue(rr(4'd1, 2'd3, 2'd2, 2'd0), 1'b1, "R3");
        // R7: logical clears overflow; R4
        issue(rr(4'd2, 2'd1, 2'd0, 2'd2), 1'b1, "R4");
        issue(ri(4'd3, 2'd1, 2'd1, 16'h8000), 1'b1, "R4");
        // R6: shifts at the boundary
        issue(ri(4'd5, 2'd1, 2'd0, 16'd16), 1'b1, "R6");
        issue(ri(4'd6, 2'd1, 2'd0, 16'd15), 1'b1, "R6");
        issue(rr(4'd5, 2'd3, 2'd0, 2'd2), 1'b1, "R6");
        issue(ri(4'd6, 2'd3, 2'd0, 16'h0100), 1'b1, "R6");
        // R2: distinct fields reach their own registers
        issue(rr(4'd0, 2'd2, 2'd3, 2'd1), 1'b1, "R2");
        // R8: valid low has no effect
        issue(ri(4'd4, 2'd0, 2'd0, 16'h1234), 1'b0, "R8");
        // R9: malformed words, then the pulse ends
        issue(ri(4'd9, 2'd0, 2'd0, 16'h0000), 1'b1, "R9");
        issue(32'd0, 1'b0, "R9");
        issue({4'd7, 3'd5, 25'h0000003}, 1'b1, "R9");
        issue(32'd0, 1'b0, "R9");
        // R10: stage form and a foreign class
        issue({4'd7, 3'd2, 4'd0, 21'h1FFFFF}, 1'b1, "R10");
        issue({4'd3, 3'd0, 4'd0, 21'h000007}, 1'b1, "R10");

        // Constrained random stream
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] ins;
            logic [3:0]  sub;
            logic [15:0] imm;
            int          pick;
            pick = $urandom_range(99);
            sub  = (pick < 90) ? 4'($urandom_range(6)) : 4'($urandom_range(15));
            imm  = ($urandom_range(3) == 0) ? 16'($urandom_range(20)) : 16'($urandom);
            if (pick < 45)      ins = rr(sub, 2'($urandom), 2'($urandom), 2'($urandom));
            else if (pick < 88) ins = ri(sub, 2'($urandom), 2'($urandom), imm);
            else if (pick < 94) ins = {4'd7, 3'($urandom_range(7)), 25'($urandom)};
            else                ins = $urandom;
            issue(ins, ($urandom_range(9) != 0), tag_of(ins));
        end

        // R1: reset clears a populated state
        issue(ri(4'd4, 2'd3, 2'd0, 16'hBEEF), 1'b1, "R5");
        do_reset();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule